// File: doc/BRIEF.md
# Converter Start-Up Sequencer

This block brings an audio converter out of reset. When the active-low reset is released it starts a stand-alone start-up timer. The timer counts rising edges of the frame clock, which is synchronised into the system-clock domain first. When the timer expires, the block enables the voltage reference and waits for a fixed number of system-clock cycles. After that wait it reports the converter as powered.

A configuration-enable strobe can arrive while the stand-alone timer is still running. In that case the timer is abandoned and the block pulses a register-clear output, so the register file returns to its defaults. The block then stays in register-controlled mode. In that mode the converter stays powered down while the external power-down bit is 1. When software clears the bit, the same timed power-up runs. Setting the bit back to 1 later powers the converter down again. A strobe that arrives after the stand-alone timer has expired has no effect.

The register file itself, the analog reference and clock-stability detection live outside this block. The register file can be accessed as soon as reset is released, and this block imposes no lock on it.

Top module: `pwrup_seq`

## Requirements
- R1: While `rst_n` is low, `reg_clear` is 1 and `ref_en`, `powered` and `ctl_mode` are 0.
- R2: One clock after reset is released, `reg_clear` returns to 0. `ref_en` stays 0 while the stand-alone timer runs.
- R3: In stand-alone mode, `ref_en` rises within four system clocks of the SA_FRAMES-th rising edge of `frame_clk`, and not before that edge.
- R4: `powered` rises exactly PU_CYCLES system clocks after `ref_en` rises. `powered` is never 1 while `ref_en` is 0.
- R5: A `cfg_en_stb` pulse seen while the stand-alone timer is running has the following effect one clock later: `ctl_mode` is 1 and `reg_clear` is 1 for exactly one clock. `ref_en` stays 0. When the strobe coincides with the final frame edge, the strobe wins.
- R6: In register-controlled mode, `ref_en` and `powered` stay 0 for as long as `pd_bit` is 1.
- R7: In register-controlled mode, `ref_en` rises one clock after `pd_bit` is seen at 0. `powered` follows as described in R4.
- R8: A `cfg_en_stb` pulse has no effect on `ctl_mode` and produces no `reg_clear` pulse if it arrives in either of these situations: the stand-alone timer has expired (`ref_en` already 1 in stand-alone mode), or the block is already in register-controlled mode.
- R9: In register-controlled mode, `pd_bit` going to 1 during the power-up wait or after power-up drops `ref_en` and `powered` one clock later.
- R10: In stand-alone mode, `pd_bit` has no effect on any output.
- R11: Once `ctl_mode` is 1, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clk | input | 1 | Left/right frame clock, asynchronous to `clk` |
| cfg_en_stb | input | 1 | One-cycle configuration-enable write strobe |
| pd_bit | input | 1 | Power-down register bit (1 = stay powered down) |
| reg_clear | output | 1 | Forces the register file to its defaults |
| ctl_mode | output | 1 | 1 = register-controlled start-up selected |
| ref_en | output | 1 | Reference enable |
| powered | output | 1 | Converter fully powered |

## Verification
A wrong mode or sequencer state shows up at the ports within one clock of the stimulus that should have moved it. Examples are a strobe that is ignored or taken in error, a power-down bit that is acted on in stand-alone mode, and a missing drop on `pd_bit`. Each of these changes `ctl_mode`, `reg_clear` or `ref_en` on the next clock. A frame counter that miscounts moves the rise of `ref_en` by one whole frame period. A ramp counter that is off by one moves the rise of `powered` by one clock, so the bench measures that delay to the exact cycle.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    typedef enum logic [1:0] {
        ST_SA_WAIT = 2'd0,
        ST_CP_DOWN = 2'd1,
        ST_RAMP    = 2'd2,
        ST_UP      = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       ctl;
        logic       clear;
    } seq_regs_t;

endpackage

// File: rtl/pwrup_edge_sync.sv
module pwrup_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pwrup_count.sv
module pwrup_count #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_last = (cnt_q == LAST);
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int SA_FRAMES   = 1024,
    parameter int PU_CYCLES   = 2500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_clk,
    input  logic cfg_en_stb,
    input  logic pd_bit,
    output logic reg_clear,
    output logic ctl_mode,
    output logic ref_en,
    output logic powered
);
    seq_regs_t r_d, r_q;
    logic fr_rise, frame_last, ramp_last;
    logic in_wait, in_ramp, sa_done, ramp_done;

    pwrup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(frame_clk), .rise(fr_rise)
    );

    assign in_wait = (r_q.state == ST_SA_WAIT);
    assign in_ramp = (r_q.state == ST_RAMP);

    pwrup_count #(.LIMIT(SA_FRAMES)) u_frames (
        .clk(clk), .rst_n(rst_n), .clr(!in_wait), .inc(in_wait && fr_rise),
        .at_last(frame_last)
    );

    pwrup_count #(.LIMIT(PU_CYCLES)) u_ramp (
        .clk(clk), .rst_n(rst_n), .clr(!in_ramp), .inc(in_ramp),
        .at_last(ramp_last)
    );

    assign sa_done   = fr_rise && frame_last;
    assign ramp_done = in_ramp && ramp_last;

    always_comb begin
        r_d       = r_q;
        r_d.clear = 1'b0;
        unique case (r_q.state)
            ST_SA_WAIT: begin
                if (cfg_en_stb) begin
                    r_d.state = ST_CP_DOWN;
                    r_d.ctl   = 1'b1;
                    r_d.clear = 1'b1;
                end else if (sa_done) begin
                    r_d.state = ST_RAMP;
                end
            end
            ST_CP_DOWN: begin
                if (!pd_bit) r_d.state = ST_RAMP;
            end
            ST_RAMP: begin
                if (r_q.ctl && pd_bit) r_d.state = ST_CP_DOWN;
                else if (ramp_done)    r_d.state = ST_UP;
            end
            ST_UP: begin
                if (r_q.ctl && pd_bit) r_d.state = ST_CP_DOWN;
            end
            default: r_d.state = ST_SA_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_SA_WAIT;
            r_q.ctl   <= 1'b0;
            r_q.clear <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_clear = r_q.clear;
    assign ctl_mode  = r_q.ctl;
    assign ref_en    = (r_q.state == ST_RAMP) || (r_q.state == ST_UP);
    assign powered   = (r_q.state == ST_UP);
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en_stb,
    input logic pd_bit,
    input logic reg_clear,
    input logic ctl_mode,
    input logic ref_en,
    input logic powered
);
    p_powered_needs_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        powered |-> ref_en);

    p_powered_after_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered) |-> $past(ref_en));

    p_clear_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clear |=> !reg_clear);

    p_hold_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode && pd_bit && !ref_en) |=> !ref_en);

    p_late_strobe_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && !ctl_mode) |=> (!ctl_mode && !reg_clear));

    p_drop_on_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode && pd_bit) |=> !powered);

    p_mode_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_mode |=> ctl_mode);

    p_strobe_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en_stb && !ref_en && !ctl_mode) |=> ctl_mode);
endmodule

bind pwrup_seq pwrup_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en_stb(cfg_en_stb), .pd_bit(pd_bit),
    .reg_clear(reg_clear), .ctl_mode(ctl_mode), .ref_en(ref_en), .powered(powered)
);

// File: tb/sim_pwrup_seq.sv
`timescale 1ns/1ps
module sim_pwrup_seq;
    localparam int SAF = 16;
    localparam int PUC = 40;
    localparam int NSC = 5;
    localparam int CFG_AT [NSC] = '{-1, 3, 15, 20, 3};
    localparam bit PD_REL [NSC] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam bit EXP_CTL[NSC] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam bit EXP_PWR[NSC] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_clk = 1'b0;
    logic cfg_en_stb = 1'b0;
    logic pd_bit = 1'b1;
    logic reg_clear, ctl_mode, ref_en, powered;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwrup_seq #(.SA_FRAMES(SAF), .PU_CYCLES(PUC)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .cfg_en_stb(cfg_en_stb),
        .pd_bit(pd_bit), .reg_clear(reg_clear), .ctl_mode(ctl_mode),
        .ref_en(ref_en), .powered(powered)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic one_frame();
        frame_clk = 1'b1;
        repeat (4) @(negedge clk);
        frame_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic strobe();
        cfg_en_stb = 1'b1;
        @(negedge clk);
        cfg_en_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        frame_clk = 1'b0;
        cfg_en_stb = 1'b0;
        pd_bit = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 reg_clear", reg_clear, 1);
        check("R1 ref_en", ref_en, 0);
        check("R1 powered", powered, 0);
        check("R1 ctl_mode", ctl_mode, 0);

        // Scenario table
        for (int s = 0; s < NSC; s++) begin
            do_reset();
            @(negedge clk);
            for (int f = 0; f < 40; f++) begin
                if (f == CFG_AT[s]) begin
                    strobe();
                    if (PD_REL[s]) pd_bit = 1'b0;
                end
                one_frame();
            end
            check($sformatf("R5/R8 table %0d ctl_mode", s), ctl_mode, EXP_CTL[s]);
            check($sformatf("R3/R6/R7 table %0d powered", s), powered, EXP_PWR[s]);
            check($sformatf("R4 table %0d ref_en", s), ref_en, EXP_PWR[s]);
        end

        // R2, R3, R4, R10: stand-alone with pd_bit low the whole time
        do_reset();
        pd_bit = 1'b0;
        @(negedge clk);
        check("R2 reg_clear drop", reg_clear, 0);
        for (int f = 0; f < SAF - 1; f++) one_frame();
        check("R2/R3 ref_en before last edge", ref_en, 0);
        check("R10 ctl_mode with pd low", ctl_mode, 0);
        frame_clk = 1'b1;
        @(negedge clk);
        check("R3 ref_en not early", ref_en, 0);
        n = 1;
        while (!ref_en && n < 10) begin @(negedge clk); n++; end
        check("R3 ref_en within 4 clocks", (n <= 4) ? 1 : 0, 1);
        frame_clk = 1'b0;
        n = 0;
        while (!powered && n < 1000) begin @(negedge clk); n++; end
        check("R4 ramp length", n, PUC);
        pd_bit = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 pd ignored powered", powered, 1);
        check("R10 pd ignored ref_en", ref_en, 1);
        strobe();
        check("R8 late strobe ctl_mode", ctl_mode, 0);
        check("R8 late strobe reg_clear", reg_clear, 0);

        // R5, R6, R7, R9, R11: register-controlled path
        do_reset();
        @(negedge clk);
        one_frame();
        one_frame();
        strobe();
        check("R5 ctl_mode", ctl_mode, 1);
        check("R5 reg_clear pulse", reg_clear, 1);
        @(negedge clk);
        check("R5 reg_clear one cycle", reg_clear, 0);
        check("R5 ref_en low", ref_en, 0);
        for (int f = 0; f < 30; f++) one_frame();
        check("R6 held down ref_en", ref_en, 0);
        check("R6 held down powered", powered, 0);
        strobe();
        check("R8 repeat strobe reg_clear", reg_clear, 0);
        check("R11 ctl_mode sticky", ctl_mode, 1);
        pd_bit = 1'b0;
        @(negedge clk);
        check("R7 ref_en one clock", ref_en, 1);
        n = 0;
        while (!powered && n < 1000) begin @(negedge clk); n++; end
        check("R7 ramp length", n, PUC);
        pd_bit = 1'b1;
        @(negedge clk);
        check("R9 drop ref_en", ref_en, 0);
        check("R9 drop powered", powered, 0);
        pd_bit = 1'b0;
        repeat (5) @(negedge clk);
        pd_bit = 1'b1;
        @(negedge clk);
        check("R9 drop during ramp", ref_en, 0);
        check("R11 ctl_mode kept", ctl_mode, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule